// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers every interrupt cause of a full-speed USB device controller into one 16-bit status word for a register bus. It also drives a single interrupt line. The low eight bits carry one flag per endpoint. Each of these flags follows that endpoint's pending cause flags as a level. The bits above them record bus events and hold their value until firmware clears them.

The block contains its own idle timer, which spots a quiet bus and puts the device into the suspended state. It also contains a synchronizer with an edge detector for an asynchronous remote-wakeup request. While the device is suspended, that request is recorded, and when remote wakeup is allowed the block also asks the line driver to signal resume on the bus.

The sticky bits are cleared by a write-one-to-clear strobe. A per-bit mask selects which status bits reach the interrupt line.

Top module: `usb_irq_status_agg`

## Requirements
- R1: Status bit positions are fixed: bits 0..7 belong to endpoints 0..7, bit 8 is suspend, bit 9 is resume, bit 10 is external resume, bit 11 is start-of-frame and bit 13 is wakeup. Bits 12, 14 and 15 always read 0. After reset the whole word, `irq_o`, `suspended_o` and `drive_resume_o` are 0.
- R2: Endpoint bit e is 1 in the same cycle whenever any of that endpoint's five cause inputs (setup, bank 0, bank 1, transmit done, stall sent) is 1, and 0 otherwise.
- R3: When `bus_activity_i` has been low for IDLE_CYCLES consecutive rising edges, the suspend bit (8) and `suspended_o` go to 1. Any activity cycle restarts that count from zero.
- R4: An activity cycle drops `suspended_o` at the next edge. It leaves the sticky suspend bit set. While the device is suspended, the timer holds and raises no new suspend event.
- R5: A `resume_det_i` strobe sets the resume bit (9) at the next edge.
- R6: A rising edge on `send_resume_i` passes through two synchronizer flops. If the device is suspended when that edge is detected, the external-resume bit (10) is set at the third rising clock edge after the change. An edge that arrives while the device is not suspended is ignored.
- R7: When R6 sets bit 10 and `remote_wake_en_i` is 1, `drive_resume_o` is 1 for exactly that one cycle. When `remote_wake_en_i` is 0, it stays at 0.
- R8: A `sof_det_i` strobe sets the start-of-frame bit (11) at the next edge.
- R9: A `resume_det_i` or `reset_det_i` strobe sets the wakeup bit (13) at the next edge.
- R10: With `clr_wr_i` high, each 1 in `clr_data_i` clears the matching sticky bit (8, 9, 10, 11, 13) at the next edge. Zeros in `clr_data_i` do nothing. Endpoint and reserved bits are unaffected by the clear.
- R11: When a set and a clear hit the same sticky bit in one cycle, the bit ends up set.
- R12: `irq_o` equals the OR of `status_o & irq_mask_i`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ep_setup_i | input | NUM_EP | Setup packet pending, per endpoint |
| ep_bank0_i | input | NUM_EP | Receive bank 0 full, per endpoint |
| ep_bank1_i | input | NUM_EP | Receive bank 1 full, per endpoint |
| ep_txdone_i | input | NUM_EP | Transmit acknowledged, per endpoint |
| ep_stall_i | input | NUM_EP | Stall handshake sent, per endpoint |
| bus_activity_i | input | 1 | Bus activity seen this cycle |
| sof_det_i | input | 1 | Start-of-frame token strobe |
| resume_det_i | input | 1 | Resume signalling detected strobe |
| reset_det_i | input | 1 | Bus reset detected strobe |
| send_resume_i | input | 1 | Asynchronous remote-wakeup request |
| remote_wake_en_i | input | 1 | Remote wakeup allowed |
| clr_wr_i | input | 1 | Clear-register write strobe |
| clr_data_i | input | 16 | Write-one-to-clear data |
| irq_mask_i | input | 16 | Interrupt enable per status bit |
| status_o | output | 16 | Interrupt status word |
| irq_o | output | 1 | Combined masked interrupt |
| suspended_o | output | 1 | Device in suspend state |
| drive_resume_o | output | 1 | One-cycle request to drive resume on the bus |

## Verification
The assertions assume that the detect strobes and `clr_wr_i` are synchronous to `clk_i` and are already filtered to one cycle per event. They also assume that `send_resume_i` is the only input changing out of phase with the clock. The stimulus changes every input one time unit after the rising edge, `send_resume_i` included, so no input changes close to the sampling edge. The stimulus reaches the timer boundary with an idle count of 40 cycles, and it drives the wakeup request both inside and outside the suspended state.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned MAX_EP   = 8;
  localparam int unsigned BIT_SUSP = 8;
  localparam int unsigned BIT_RES  = 9;
  localparam int unsigned BIT_EXT  = 10;
  localparam int unsigned BIT_SOF  = 11;
  localparam int unsigned BIT_WAKE = 13;
  localparam int unsigned N_EVT    = 5;

  typedef logic [STAT_W-1:0] stat_t;

  // event order inside the sticky bank
  typedef enum int unsigned {
    EV_SUSP = 0,
    EV_RES  = 1,
    EV_EXT  = 2,
    EV_SOF  = 3,
    EV_WAKE = 4
  } evt_e;

  function automatic int unsigned evt_pos(int unsigned idx);
    case (idx)
      0:       return BIT_SUSP;
      1:       return BIT_RES;
      2:       return BIT_EXT;
      3:       return BIT_SOF;
      default: return BIT_WAKE;
    endcase
  endfunction
endpackage

// File: rtl/ep_cause_or.sv
module ep_cause_or #(
  parameter int unsigned NUM_EP = 8
) (
  input  logic [NUM_EP-1:0] setup_i,
  input  logic [NUM_EP-1:0] bank0_i,
  input  logic [NUM_EP-1:0] bank1_i,
  input  logic [NUM_EP-1:0] txdone_i,
  input  logic [NUM_EP-1:0] stall_i,
  output logic [NUM_EP-1:0] ep_irq_o
);
  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign ep_irq_o[e] = setup_i[e] | bank0_i[e] | bank1_i[e] | txdone_i[e] | stall_i[e];
  end
endmodule

// File: rtl/idle_suspend_timer.sv
module idle_suspend_timer #(
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  output logic suspend_set_o,
  output logic suspended_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          susp_q;
  logic          hit;

  assign hit           = (cnt_q == LAST);
  assign suspend_set_o = !activity_i && !susp_q && hit;
  assign suspended_o   = susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else if (activity_i) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else if (!susp_q) begin
      if (hit) susp_q <= 1'b1;
      else     cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/resume_req_sync.sv
module resume_req_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_resume_i,
  input  logic suspended_i,
  input  logic remote_wake_en_i,
  output logic ext_set_o,
  output logic drive_resume_o
);
  logic [SYNC_STAGES:0] chain_q;
  logic                 rise;
  logic                 drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], send_resume_i};
  end

  // top stage is the history flop for edge detection
  assign rise      = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign ext_set_o = rise & suspended_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= ext_set_o & remote_wake_en_i;
  end

  assign drive_resume_o = drv_q;
endmodule

// File: rtl/sticky_evt_bank.sv
module sticky_evt_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/usb_irq_status_agg.sv
module usb_irq_status_agg
  import usb_irq_pkg::*;
#(
  parameter int unsigned NUM_EP      = 8,
  parameter int unsigned IDLE_CYCLES = 144000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] ep_setup_i,
  input  logic [NUM_EP-1:0] ep_bank0_i,
  input  logic [NUM_EP-1:0] ep_bank1_i,
  input  logic [NUM_EP-1:0] ep_txdone_i,
  input  logic [NUM_EP-1:0] ep_stall_i,
  input  logic              bus_activity_i,
  input  logic              sof_det_i,
  input  logic              resume_det_i,
  input  logic              reset_det_i,
  input  logic              send_resume_i,
  input  logic              remote_wake_en_i,
  input  logic              clr_wr_i,
  input  logic [15:0]       clr_data_i,
  input  logic [15:0]       irq_mask_i,
  output logic [15:0]       status_o,
  output logic              irq_o,
  output logic              suspended_o,
  output logic              drive_resume_o
);
  logic [NUM_EP-1:0] ep_irq;
  logic              susp_set;
  logic              susp_st;
  logic              ext_set;
  logic [N_EVT-1:0]  evt_set;
  logic [N_EVT-1:0]  evt_clr;
  logic [N_EVT-1:0]  evt_q;
  stat_t             stat;

  ep_cause_or #(.NUM_EP(NUM_EP)) u_ep (
    .setup_i  (ep_setup_i),
    .bank0_i  (ep_bank0_i),
    .bank1_i  (ep_bank1_i),
    .txdone_i (ep_txdone_i),
    .stall_i  (ep_stall_i),
    .ep_irq_o (ep_irq)
  );

  idle_suspend_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .activity_i    (bus_activity_i),
    .suspend_set_o (susp_set),
    .suspended_o   (susp_st)
  );

  resume_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .send_resume_i    (send_resume_i),
    .suspended_i      (susp_st),
    .remote_wake_en_i (remote_wake_en_i),
    .ext_set_o        (ext_set),
    .drive_resume_o   (drive_resume_o)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_SUSP] = susp_set;
    evt_set[EV_RES]  = resume_det_i;
    evt_set[EV_EXT]  = ext_set;
    evt_set[EV_SOF]  = sof_det_i;
    evt_set[EV_WAKE] = resume_det_i | reset_det_i;
    for (int i = 0; i < N_EVT; i++) begin
      evt_clr[i] = clr_wr_i & clr_data_i[evt_pos(i)];
    end
  end

  sticky_evt_bank #(.N(N_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .q_o    (evt_q)
  );

  always_comb begin
    stat = '0;
    stat[NUM_EP-1:0] = ep_irq;
    for (int i = 0; i < N_EVT; i++) begin
      stat[evt_pos(i)] = evt_q[i];
    end
  end

  assign status_o    = stat;
  assign irq_o       = |(stat & irq_mask_i);
  assign suspended_o = susp_st;
endmodule

// File: rtl/usb_irq_status_agg_chk.sv
module usb_irq_status_agg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_activity_i,
  input logic        sof_det_i,
  input logic        resume_det_i,
  input logic        reset_det_i,
  input logic        remote_wake_en_i,
  input logic        clr_wr_i,
  input logic [15:0] clr_data_i,
  input logic [15:0] status_o,
  input logic        suspended_o,
  input logic        drive_resume_o
);
  a_r4_activity_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_activity_i |=> !suspended_o);
  a_r3_suspend_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspended_o) |-> status_o[8]);
  a_r5_resume_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_det_i |=> status_o[9]);
  a_r8_sof_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_det_i |=> status_o[11]);
  a_r9_wake_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_det_i || reset_det_i) |=> status_o[13]);
  a_r10_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_data_i[11] && !sof_det_i) |=> !status_o[11]);
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_data_i[13] && reset_det_i) |=> status_o[13]);
  a_r7_drive_with_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_resume_o |-> (status_o[10] && $past(remote_wake_en_i)));
  a_r7_drive_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_resume_o |=> !drive_resume_o);
endmodule

bind usb_irq_status_agg usb_irq_status_agg_chk u_chk (.*);

// File: tb/sim_usb_irq_status_agg.sv
`timescale 1ns/1ps
module sim_usb_irq_status_agg;
  localparam int NEP  = 8;
  localparam int IDLE = 40;

  logic clk_i = 0, rst_ni = 0;
  logic [NEP-1:0] ep_setup_i = 0, ep_bank0_i = 0, ep_bank1_i = 0, ep_txdone_i = 0, ep_stall_i = 0;
  logic bus_activity_i = 0, sof_det_i = 0, resume_det_i = 0, reset_det_i = 0;
  logic send_resume_i = 0, remote_wake_en_i = 0, clr_wr_i = 0;
  logic [15:0] clr_data_i = 0, irq_mask_i = 0;
  logic [15:0] status_o;
  logic irq_o, suspended_o, drive_resume_o;

  usb_irq_status_agg #(.NUM_EP(NEP), .IDLE_CYCLES(IDLE)) u0 (.*);

  always #5 clk_i = ~clk_i;

  int errors = 0, checks = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  bit m_susp_f, m_res, m_ext, m_sof, m_wake, m_suspended, m_drive;
  bit m_s1, m_s2, m_s3;
  int m_idle;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_susp_f, m_res, m_ext, m_sof, m_wake, m_suspended, m_drive} = 0;
      {m_s1, m_s2, m_s3} = 0;
      m_idle = 0;
    end else begin
      bit edge_now, s_old, sset;
      logic [15:0] c;
      edge_now = m_s2 && !m_s3;
      s_old    = m_suspended;
      c        = clr_wr_i ? clr_data_i : 16'h0;
      sset     = !bus_activity_i && !s_old && (m_idle == IDLE - 1);
      m_sof    = sof_det_i || (m_sof && !c[11]);
      m_res    = resume_det_i || (m_res && !c[9]);
      m_wake   = resume_det_i || reset_det_i || (m_wake && !c[13]);
      m_ext    = (edge_now && s_old) || (m_ext && !c[10]);
      m_drive  = edge_now && s_old && remote_wake_en_i;
      m_susp_f = sset || (m_susp_f && !c[8]);
      if (bus_activity_i) begin m_idle = 0; m_suspended = 0; end
      else if (!s_old) begin
        if (m_idle == IDLE - 1) m_suspended = 1; else m_idle++;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = send_resume_i;
    end
  end

  function automatic logic [15:0] exp_status();
    logic [15:0] s = 0;
    for (int e = 0; e < NEP; e++)
      s[e] = ep_setup_i[e] | ep_bank0_i[e] | ep_bank1_i[e] | ep_txdone_i[e] | ep_stall_i[e];
    s[8] = m_susp_f; s[9] = m_res; s[10] = m_ext; s[11] = m_sof; s[13] = m_wake;
    return s;
  endfunction

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (!done) begin
    logic [15:0] es;
    es = exp_status();
    chk("status", status_o, es);
    chk("irq", {15'h0, irq_o}, {15'h0, |(es & irq_mask_i)});
    chk("suspended", {15'h0, suspended_o}, {15'h0, m_suspended});
    chk("drive_resume", {15'h0, drive_resume_o}, {15'h0, m_drive});
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic clr(logic [15:0] d);
    clr_wr_i = 1; clr_data_i = d; tick(); clr_wr_i = 0; clr_data_i = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    phase = "R1_reset";
    tick(3);
    rst_ni = 1; bus_activity_i = 1;
    tick(2);

    phase = "R2_ep_levels";
    for (int e = 0; e < NEP; e++) begin
      ep_setup_i[e] = 1;  tick(); ep_setup_i[e] = 0;
      ep_bank0_i[e] = 1;  tick(); ep_bank0_i[e] = 0;
      ep_bank1_i[e] = 1;  tick(); ep_bank1_i[e] = 0;
      ep_txdone_i[e] = 1; tick(); ep_txdone_i[e] = 0;
      ep_stall_i[e] = 1;  tick(); ep_stall_i[e] = 0;
      tick();
    end
    ep_setup_i = 8'hA5; ep_stall_i = 8'h5A; tick(2);
    phase = "R10_ep_not_clearable";
    clr(16'hFFFF); tick();
    ep_setup_i = 0; ep_stall_i = 0; tick();

    phase = "R8_sof";    sof_det_i = 1; tick(); sof_det_i = 0; tick(2);
    phase = "R5_resume"; resume_det_i = 1; tick(); resume_det_i = 0; tick(2);
    phase = "R9_reset";  clr(16'h2000); reset_det_i = 1; tick(); reset_det_i = 0; tick(2);
    phase = "R10_zero_no_effect"; clr(16'h0000); tick();
    phase = "R12_mask";
    ep_bank1_i = 8'h10;
    for (int b = 0; b < 16; b++) begin irq_mask_i = 16'h1 << b; tick(); end
    irq_mask_i = 16'h5000; tick(); irq_mask_i = 16'hFFFF; tick();
    ep_bank1_i = 0; tick();
    phase = "R10_clear";   clr(16'h0800); tick(); clr(16'h2200); tick();
    phase = "R11_set_wins";
    sof_det_i = 1; clr_wr_i = 1; clr_data_i = 16'h0800; tick();
    sof_det_i = 0; clr_wr_i = 0; clr_data_i = 0; tick();
    reset_det_i = 1; clr_wr_i = 1; clr_data_i = 16'h2000; tick();
    reset_det_i = 0; clr_wr_i = 0; clr_data_i = 0; tick();
    phase = "R10_clear_all"; clr(16'hFFFF); tick();

    phase = "R3_idle_restart";
    bus_activity_i = 0; tick(IDLE - 5);
    bus_activity_i = 1; tick(); bus_activity_i = 0;
    phase = "R3_idle_suspend"; tick(IDLE + 5);
    phase = "R4_activity_exit"; bus_activity_i = 1; tick(); bus_activity_i = 0; tick(3);
    clr(16'h0100); tick(IDLE + 3);

    phase = "R6_R7_remote_wake";
    remote_wake_en_i = 1; send_resume_i = 1; tick(6);
    clr(16'h0400); send_resume_i = 0; tick(4);
    phase = "R7_wake_disabled";
    remote_wake_en_i = 0; send_resume_i = 1; tick(6); send_resume_i = 0; tick(4);
    clr(16'h0400);
    phase = "R6_not_suspended";
    bus_activity_i = 1; tick(2);
    remote_wake_en_i = 1; send_resume_i = 1; tick(6); send_resume_i = 0; tick(3);
    phase = "R1_final"; clr(16'hFFFF); tick(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule